// File: doc/BRIEF.md
# External Memory Read Sequencer with Ready

This block performs read cycles on an external parallel memory bus on behalf of one internal requester. A request carries an address; once it is accepted the block pulls the select line low, drives the address, and walks through three programmable phases counted in interface clock cycles. The first is a setup phase with the strobe high. The second is a strobe phase with the read strobe low. The third is a recovery phase after the strobe has been released while select is still low. The phase lengths and the ready mode are taken from configuration inputs when a request is accepted and are held for the whole access.

A ready input from the memory can lengthen the strobe phase with wait states. In direct mode the raw input is tested on each decision edge. In resynchronised mode the input first passes through a two-flop chain, so the value that is tested was taken two edges earlier. The strobe phase needs a minimum length in this mode, and a smaller setting is raised to that minimum. The data word is captured on the edge that releases the strobe. It is returned with a one-cycle completion pulse when select goes high. The address lines keep their last value until the next access is accepted.

Top module: `ext_rd_sequencer`

## Requirements
- R1: While reset is asserted and directly after it, sel_n and strobe_n are high, ack and done are low and bus_addr is zero.
- R2: A request is accepted only when no access is running. On acceptance ack is high for exactly one cycle (cycle 0 of the access). From cycle 0 sel_n is low and bus_addr equals req_addr, and strobe_n stays high for the setup length. A setup setting of 0 is treated as 1.
- R3: In direct mode with ready high, strobe_n goes low in cycle S (S = effective setup length) and stays low for exactly the strobe setting, where a setting of 0 is treated as 1.
- R4: In direct mode, ready is tested on edge S+P+n-1 for test n = 1, 2, ..., counting edge 0 as the accepting edge and P as the effective strobe length. A high value releases the strobe on that edge. Each low value adds one strobe cycle.
- R5: In resynchronised mode (cfg_resync = 1), the value tested on edge S+P+n-1 is the ready input as it was taken at edge S+P+n-3. Ready that rises two edges before the first decision edge causes no wait state, and ready that rises one edge later causes one.
- R6: In resynchronised mode, a strobe setting below 2 is treated as 2.
- R7: rd_data holds the bus_data value present on the edge where strobe_n returns high. It is valid while done is high. done is a one-cycle pulse in the first cycle with sel_n high after the access.
- R8: After the strobe is released, sel_n stays low for exactly the recovery setting (0 allowed). With ready high the whole access has sel_n low for setup + strobe + recovery cycles.
- R9: bus_addr changes only on acceptance of a request. It holds the last address during and after the access, including idle cycles.
- R10: A request held high during a running access neither restarts it nor changes bus_addr. It is accepted only after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Read request from the requester |
| req_addr | input | ADDR_W | Address of the requested read |
| ack | output | 1 | One-cycle pulse: request accepted |
| done | output | 1 | One-cycle pulse: read finished, rd_data valid |
| rd_data | output | DATA_W | Captured read data |
| cfg_setup | input | CNT_W | Setup phase length in cycles |
| cfg_strobe | input | CNT_W | Minimum strobe phase length in cycles |
| cfg_recover | input | CNT_W | Recovery phase length in cycles |
| cfg_resync | input | 1 | 1 = ready through the two-flop chain, 0 = direct |
| sel_n | output | 1 | Active-low memory select |
| strobe_n | output | 1 | Active-low read strobe |
| bus_addr | output | ADDR_W | Memory address lines |
| bus_data | input | DATA_W | Memory read data lines |
| bus_ready | input | 1 | Ready from the memory |

## Verification
The hardest case to reach is the resynchronised mode. There the decision about a wait state depends on the ready level two edges before the decision edge, so ready must change at a precise edge before the strobe phase has even ended. The bench numbers every edge from the accepting edge. On each falling clock edge it drives the ready level for the coming edge from a chosen rise edge. It then places that rise exactly two edges before, and one edge before, the first decision edge, and so tells the early test apart from a late one. The data bus carries a value that changes on every edge, so a capture on the wrong edge shows up as a wrong word.

// File: rtl/ext_rd_pkg.sv
package ext_rd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_STRB  = 2'd2,
      ST_RECOV = 2'd3
   } rd_state_e;
endpackage

// File: rtl/ext_rd_cfg_clamp.sv
module ext_rd_cfg_clamp #(
   parameter int CNT_W      = 4,
   parameter int SYNC_DEPTH = 2
) (
   input  logic [CNT_W-1:0] cfg_setup,
   input  logic [CNT_W-1:0] cfg_strobe,
   input  logic             cfg_resync,
   output logic [CNT_W-1:0] setup_eff,
   output logic [CNT_W-1:0] strobe_eff
);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
   localparam logic [CNT_W-1:0] MIN_RES = CNT_W'(SYNC_DEPTH);

   always_comb begin
      setup_eff = (cfg_setup == '0) ? ONE : cfg_setup;
      if (cfg_resync)
         strobe_eff = (cfg_strobe < MIN_RES) ? MIN_RES : cfg_strobe;
      else
         strobe_eff = (cfg_strobe == '0) ? ONE : cfg_strobe;
   end
endmodule

// File: rtl/ext_rd_ready_sampler.sv
module ext_rd_ready_sampler #(
   parameter int SYNC_DEPTH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ready_raw,
   input  logic use_resync,
   output logic ready_seen
);
   logic [SYNC_DEPTH-1:0] stage_q;

   genvar gi;
   generate
      for (gi = 0; gi < SYNC_DEPTH; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[0] <= 1'b0;
               else        stage_q[0] <= ready_raw;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[gi] <= 1'b0;
               else        stage_q[gi] <= stage_q[gi-1];
            end
         end
      end
   endgenerate

   assign ready_seen = use_resync ? stage_q[SYNC_DEPTH-1] : ready_raw;
endmodule

// File: rtl/ext_rd_sequencer.sv
module ext_rd_sequencer #(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 16,
   parameter int CNT_W      = 4,
   parameter int SYNC_DEPTH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              ack,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   input  logic [CNT_W-1:0]  cfg_setup,
   input  logic [CNT_W-1:0]  cfg_strobe,
   input  logic [CNT_W-1:0]  cfg_recover,
   input  logic              cfg_resync,
   output logic              sel_n,
   output logic              strobe_n,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              bus_ready
);
   import ext_rd_pkg::*;

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("ext_rd_sequencer: widths must be positive");
      end
      if (SYNC_DEPTH < 2) begin : g_bad_sync
         $error("ext_rd_sequencer: SYNC_DEPTH must be at least 2");
      end
      if (CNT_W < 2 || (1 << CNT_W) <= SYNC_DEPTH) begin : g_bad_cnt
         $error("ext_rd_sequencer: CNT_W too small for SYNC_DEPTH");
      end
   endgenerate

   rd_state_e         state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  setup_q, strobe_q, recov_q;
   logic              resync_q;
   logic [CNT_W-1:0]  setup_eff, strobe_eff;
   logic              ready_seen;

   ext_rd_cfg_clamp #(.CNT_W(CNT_W), .SYNC_DEPTH(SYNC_DEPTH)) u_clamp (
      .cfg_setup  (cfg_setup),
      .cfg_strobe (cfg_strobe),
      .cfg_resync (cfg_resync),
      .setup_eff  (setup_eff),
      .strobe_eff (strobe_eff)
   );

   ext_rd_ready_sampler #(.SYNC_DEPTH(SYNC_DEPTH)) u_ready (
      .clk        (clk),
      .rst_n      (rst_n),
      .ready_raw  (bus_ready),
      .use_resync (resync_q),
      .ready_seen (ready_seen)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cnt_q    <= '0;
         setup_q  <= ONE;
         strobe_q <= ONE;
         recov_q  <= '0;
         resync_q <= 1'b0;
         sel_n    <= 1'b1;
         strobe_n <= 1'b1;
         bus_addr <= '0;
         rd_data  <= '0;
         ack      <= 1'b0;
         done     <= 1'b0;
      end else begin
         ack  <= 1'b0;
         done <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req) begin
                  state_q  <= ST_SETUP;
                  cnt_q    <= '0;
                  setup_q  <= setup_eff;
                  strobe_q <= strobe_eff;
                  recov_q  <= cfg_recover;
                  resync_q <= cfg_resync;
                  bus_addr <= req_addr;
                  sel_n    <= 1'b0;
                  ack      <= 1'b1;
               end
            end
            ST_SETUP: begin
               if (cnt_q == setup_q - ONE) begin
                  state_q  <= ST_STRB;
                  cnt_q    <= '0;
                  strobe_n <= 1'b0;
               end else begin
                  cnt_q <= cnt_q + ONE;
               end
            end
            ST_STRB: begin
               if (cnt_q == strobe_q - ONE) begin
                  if (ready_seen) begin
                     strobe_n <= 1'b1;
                     rd_data  <= bus_data;
                     cnt_q    <= '0;
                     if (recov_q == '0) begin
                        state_q <= ST_IDLE;
                        sel_n   <= 1'b1;
                        done    <= 1'b1;
                     end else begin
                        state_q <= ST_RECOV;
                     end
                  end
               end else begin
                  cnt_q <= cnt_q + ONE;
               end
            end
            ST_RECOV: begin
               if (cnt_q == recov_q - ONE) begin
                  state_q <= ST_IDLE;
                  sel_n   <= 1'b1;
                  done    <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + ONE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ext_rd_checker.sv
module ext_rd_checker #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack,
   input logic              done,
   input logic              sel_n,
   input logic              strobe_n,
   input logic [ADDR_W-1:0] bus_addr
);
   // R3: the strobe is only active inside a selected access
   p_strobe_in_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_n |-> !sel_n);

   // R2: acceptance opens the setup phase with the strobe still high
   p_ack_opens_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (!sel_n && strobe_n));

   // R2: ack lasts a single cycle
   p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

   // R7: done lasts a single cycle
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: done comes with the bus released
   p_done_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (sel_n && strobe_n));

   // R9: the address moves only on acceptance
   p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bus_addr) |-> ack);

   // R10: no acceptance while an access was running
   p_no_ack_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $past(sel_n));
endmodule

bind ext_rd_sequencer ext_rd_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ack      (ack),
   .done     (done),
   .sel_n    (sel_n),
   .strobe_n (strobe_n),
   .bus_addr (bus_addr)
);

// File: tb/tb_ext_rd_sequencer.sv
module tb_ext_rd_sequencer;
   localparam int AW = 16;
   localparam int DW = 16;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          ack, done;
   logic [DW-1:0] rd_data;
   logic [CW-1:0] cfg_setup = '0, cfg_strobe = '0, cfg_recover = '0;
   logic          cfg_resync = 1'b0;
   logic          sel_n, strobe_n;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_data = '0;
   logic          bus_ready = 1'b1;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   ext_rd_sequencer #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
      .ack(ack), .done(done), .rd_data(rd_data),
      .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe),
      .cfg_recover(cfg_recover), .cfg_resync(cfg_resync),
      .sel_n(sel_n), .strobe_n(strobe_n), .bus_addr(bus_addr),
      .bus_data(bus_data), .bus_ready(bus_ready)
   );

   task automatic check(input string tag, input string what,
                        input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, actual, expected);
      end
   endtask

   // One read access. rise_edge: first edge (0 = accepting edge) with ready high.
   task automatic run_read(input string tag, input logic [AW-1:0] addr,
                           input logic [DW-1:0] base, input int setup,
                           input int strobe, input int recov, input bit resync,
                           input int rise_edge, input bit keep_req);
      int se, pe, dec, exp_strb, n_setup, n_strb, n_recov, n_ack, done_c, addr_bad;
      bit seen_low;
      logic [DW-1:0] got_data;
      se = (setup == 0) ? 1 : setup;
      if (resync) pe = (strobe < 2) ? 2 : strobe;
      else        pe = (strobe == 0) ? 1 : strobe;
      dec = resync ? ((se + pe > rise_edge + 2) ? se + pe : rise_edge + 2)
                   : ((se + pe > rise_edge) ? se + pe : rise_edge);
      exp_strb = dec - se;
      n_setup = 0; n_strb = 0; n_recov = 0; n_ack = 0; done_c = -1; addr_bad = 0;
      seen_low = 0; got_data = '0;

      @(negedge clk);
      cfg_setup = CW'(setup); cfg_strobe = CW'(strobe);
      cfg_recover = CW'(recov); cfg_resync = resync;
      req = 1'b1; req_addr = addr;
      bus_ready = (rise_edge <= 0);
      bus_data = base;
      for (int c = 0; c < 120; c++) begin
         @(negedge clk);
         if (ack) n_ack++;
         if (c == 0) check(tag, "ack in cycle 0", int'(ack), 1);
         if (!sel_n) begin
            if (bus_addr != addr) addr_bad++;
            if (!strobe_n) begin n_strb++; seen_low = 1; end
            else if (!seen_low) n_setup++;
            else n_recov++;
         end
         if (done) begin
            done_c = c;
            got_data = rd_data;
            check(tag, "sel_n high with done", int'(sel_n), 1);
         end
         if (!keep_req || done) req = 1'b0;
         if (keep_req && !done) req_addr = ~addr;
         bus_ready = (c + 1 >= rise_edge);
         bus_data = base ^ DW'(c + 1);
         if (done_c >= 0) break;
      end
      check(tag, "setup cycles", n_setup, se);
      check(tag, "strobe cycles", n_strb, exp_strb);
      check(tag, "recovery cycles", n_recov, recov);
      check(tag, "done cycle", done_c, se + exp_strb + recov);
      check(tag, "captured data", int'(got_data), int'(base ^ DW'(dec)));
      check(tag, "ack count", n_ack, 1);
      check("R9", "address mismatches during access", addr_bad, 0);
      repeat (2) @(negedge clk);
      check("R9", "address held after access", int'(bus_addr), int'(addr));
      check("R10", "no new access after done", int'(sel_n), 1);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", "sel_n in reset", int'(sel_n), 1);
      check("R1", "strobe_n in reset", int'(strobe_n), 1);
      check("R1", "ack|done in reset", int'(ack | done), 0);
      check("R1", "bus_addr in reset", int'(bus_addr), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "sel_n after reset", int'(sel_n), 1);
   endtask

   initial begin
      t_reset();
      run_read("R3", 16'h1234, 16'hA500, 2, 3, 1, 1'b0, 0, 1'b0);
      run_read("R2", 16'h0042, 16'h5A00, 0, 0, 0, 1'b0, 0, 1'b0);
      run_read("R4", 16'h2001, 16'h3300, 1, 2, 2, 1'b0, 5, 1'b0);
      run_read("R4", 16'h2002, 16'h3C00, 2, 2, 0, 1'b0, 4, 1'b0);
      run_read("R5", 16'h3003, 16'h6600, 2, 3, 0, 1'b1, 3, 1'b0);
      run_read("R5", 16'h3004, 16'h6900, 2, 3, 1, 1'b1, 4, 1'b0);
      run_read("R6", 16'h4005, 16'h7700, 1, 1, 0, 1'b1, 0, 1'b0);
      run_read("R8", 16'h5006, 16'h1100, 1, 1, 3, 1'b0, 0, 1'b0);
      run_read("R10", 16'h6007, 16'h2200, 2, 2, 3, 1'b0, 0, 1'b1);
      run_read("R7", 16'h7008, 16'h0F0F, 3, 2, 2, 1'b1, 7, 1'b0);
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule